// File: doc/BRIEF.md
# Barrel Shift Unit with Carry-Out

This block is the shift engine of an integer execution datapath. In the same cycle it takes one data operand, a raw shift count, a two-bit operation select, a width mode (32-bit or 64-bit) and the current carry flag. It returns the shifted value and the new carry flag, which holds the last bit that left the operand. There is no register and no handshake: the result follows the inputs combinationally and is sampled by whatever stage surrounds the unit.

The raw count is first reduced to the range allowed by the active width. Left shifts are turned into right shifts by reversing the bits of the active word. A single staged right shifter then does the work, with one guard bit below the word. The guard bit catches the last bit shifted out, so the carry comes from the same path as the result. A count of zero leaves both the operand and the carry flag unchanged.

Top module: `shf_unit`

## Requirements
- R1: In 32-bit mode (`wide`=0) the effective count is the low 5 bits of `raw_cnt`, so it lies in 0..31 and higher count bits have no effect.
- R2: In 64-bit mode (`wide`=1) the effective count is the low 6 bits of `raw_cnt`, so it lies in 0..63.
- R3: For select codes 00 and 01, every step of a left shift moves the bits toward the MSB and clears bit 0.
- R4: For a left shift with effective count n > 0, `cout` equals operand bit (width − n), where width is 32 or 64.
- R5: For a right shift (select 10 or 11) with effective count n > 0, `cout` equals operand bit (n − 1).
- R6: For select 10 (logical right), the n vacated upper positions of the active word are zero.
- R7: For select 11 (arithmetic right), the n vacated upper positions copy the sign bit of the unshifted operand (bit 31 or bit 63).
- R8: When the effective count is 0, `res` equals the active operand and `cout` equals `cin`.
- R9: In 32-bit mode only `opnd[31:0]` is used, and `res[63:32]` is zero.
- R10: Select 00 and select 01 give identical `res` and `cout` for the same inputs. The outputs depend only on the present inputs, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 64 | Data operand; only bits 31:0 are used in 32-bit mode |
| raw_cnt | input | 8 | Unmasked shift count |
| op_sel | input | 2 | 00 logical left, 01 arithmetic left, 10 logical right, 11 arithmetic right |
| wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| cin | input | 1 | Incoming carry flag |
| res | output | 64 | Shifted result |
| cout | output | 1 | Updated carry flag |

## Verification
The hardest cases to reach from the ports are those where masking and mode interact. Examples are a raw count such as 32 or 96 in 32-bit mode, which must act as zero and pass `cin` through, and a count equal to the width minus one, where the carry comes from the opposite end of the word. The 32-bit cases only prove anything if the upper half of the operand holds random data, so that a leak into the result can be seen. The stimulus therefore runs through all 256 raw count values for every operation and both modes. Each run uses random full 64-bit operands with a forced sign bit and a random `cin`. Directed cases then pair aliased counts and the two left-shift codes.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_ASL = 2'b01,
    OP_LSR = 2'b10,
    OP_ASR = 2'b11
  } shf_op_e;

  function automatic logic is_left(input shf_op_e op);
    return (op == OP_LSL) || (op == OP_ASL);
  endfunction

  function automatic logic is_arith_right(input shf_op_e op);
    return op == OP_ASR;
  endfunction
endpackage

// File: rtl/shf_count_mask.sv
module shf_count_mask #(
  parameter int RCW = 8,
  parameter int DW  = 64,
  parameter int NW  = 32,
  localparam int CW  = $clog2(DW),
  localparam int NCW = $clog2(NW)
) (
  input  logic [RCW-1:0] raw_cnt,
  input  logic           wide,
  output logic [CW-1:0]  cnt_eff,
  output logic           cnt_zero
);
  always_comb begin
    if (wide) cnt_eff = raw_cnt[CW-1:0];
    else      cnt_eff = CW'(raw_cnt[NCW-1:0]);
    cnt_zero = (cnt_eff == '0);
  end

  always_comb begin
    if (!wide) a_r1_narrow_range: assert (cnt_eff < CW'(NW))
      else $error("R1 narrow count out of range");
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int EW = 65,
  parameter int S  = 1
) (
  input  logic [EW-1:0] din,
  input  logic          en,
  input  logic          fill,
  output logic [EW-1:0] dout
);
  always_comb begin
    if (en) dout = {{S{fill}}, din[EW-1:S]};
    else    dout = din;
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int DW = 64,
  localparam int CW = $clog2(DW),
  localparam int EW = DW + 1
) (
  input  logic [DW-1:0] word_in,
  input  logic [CW-1:0] cnt,
  input  logic          fill,
  output logic [DW-1:0] word_out,
  output logic          guard_out
);
  logic [EW-1:0] lvl [CW+1];

  assign lvl[0] = {word_in, 1'b0};

  for (genvar k = 0; k < CW; k++) begin : g_stage
    shf_stage #(.EW(EW), .S(1 << k)) u_stage (
      .din (lvl[k]),
      .en  (cnt[k]),
      .fill(fill),
      .dout(lvl[k+1])
    );
  end

  assign word_out  = lvl[CW][EW-1:1];
  assign guard_out = lvl[CW][0];
endmodule

// File: rtl/shf_orient.sv
module shf_orient #(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic [DW-1:0] din,
  input  logic          left,
  input  logic          wide,
  input  logic          upper_fill,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] rev_full;
  logic [NW-1:0] rev_narrow;

  for (genvar i = 0; i < DW; i++) begin : g_rev_full
    assign rev_full[i] = din[DW-1-i];
  end
  for (genvar j = 0; j < NW; j++) begin : g_rev_narrow
    assign rev_narrow[j] = din[NW-1-j];
  end

  always_comb begin
    unique case ({left, wide})
      2'b11:   dout = rev_full;
      2'b10:   dout = {{(DW-NW){upper_fill}}, rev_narrow};
      2'b01:   dout = din;
      default: dout = {{(DW-NW){upper_fill}}, din[NW-1:0]};
    endcase
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int DW  = 64,
  parameter int NW  = 32,
  parameter int RCW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic [DW-1:0]  opnd,
  input  logic [RCW-1:0] raw_cnt,
  input  logic [1:0]     op_sel,
  input  logic           wide,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cout
);
  import shf_pkg::*;

  shf_op_e       op;
  logic          left, arith_r, sign_bit, fill;
  logic [CW-1:0] cnt_eff;
  logic          cnt_zero;
  logic [DW-1:0] pre_word, shifted, post_word;
  logic          guard;

  assign op       = shf_op_e'(op_sel);
  assign left     = is_left(op);
  assign arith_r  = is_arith_right(op);
  assign sign_bit = wide ? opnd[DW-1] : opnd[NW-1];
  assign fill     = arith_r & sign_bit;

  shf_count_mask #(.RCW(RCW), .DW(DW), .NW(NW)) u_mask (
    .raw_cnt (raw_cnt),
    .wide    (wide),
    .cnt_eff (cnt_eff),
    .cnt_zero(cnt_zero)
  );

  shf_orient #(.DW(DW), .NW(NW)) u_pre (
    .din       (opnd),
    .left      (left),
    .wide      (wide),
    .upper_fill(fill),
    .dout      (pre_word)
  );

  shf_barrel #(.DW(DW)) u_barrel (
    .word_in  (pre_word),
    .cnt      (cnt_eff),
    .fill     (fill),
    .word_out (shifted),
    .guard_out(guard)
  );

  shf_orient #(.DW(DW), .NW(NW)) u_post (
    .din       (shifted),
    .left      (left),
    .wide      (wide),
    .upper_fill(1'b0),
    .dout      (post_word)
  );

  assign res  = post_word;
  assign cout = cnt_zero ? cin : guard;

  always_comb begin
    if (!wide) a_r9_upper_zero: assert (res[DW-1:NW] == '0)
      else $error("R9 upper half not zero");
    if (cnt_zero) a_r8_pass_through: assert (cout == cin &&
        res == (wide ? opnd : {{(DW-NW){1'b0}}, opnd[NW-1:0]}))
      else $error("R8 zero count changed state");
    if (left && !cnt_zero) a_r3_lsb_clear: assert (res[0] == 1'b0)
      else $error("R3 left shift left bit 0 set");
    if (op == OP_LSR && !cnt_zero) a_r6_top_zero: assert (
        (wide ? res[DW-1] : res[NW-1]) == 1'b0)
      else $error("R6 logical right top bit set");
    if (!left && !cnt_zero) a_r5_right_carry: assert (cout == opnd[cnt_eff - 1'b1])
      else $error("R5 right carry mismatch");
  end
endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
  logic        clk = 1'b0;
  logic [63:0] opnd;
  logic [7:0]  raw_cnt;
  logic [1:0]  op_sel;
  logic        wide, cin;
  logic [63:0] res;
  logic        cout;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shf_unit u0 (
    .opnd(opnd), .raw_cnt(raw_cnt), .op_sel(op_sel),
    .wide(wide), .cin(cin), .res(res), .cout(cout)
  );

  function automatic void ref_shift(input logic [63:0] d, input logic [7:0] raw,
      input logic [1:0] op, input logic w, input logic ci,
      output logic [63:0] r, output logic co);
    int width = w ? 64 : 32;
    int n = w ? int'(raw & 8'd63) : int'(raw & 8'd31);
    logic [63:0] x = w ? d : {32'b0, d[31:0]};
    logic sgn = x[width-1];
    co = ci;
    for (int i = 0; i < n; i++) begin
      if (!op[1]) begin
        co = x[width-1];
        x = x << 1;
        if (!w) x[63:32] = '0;
      end else begin
        co = x[0];
        x = x >> 1;
        x[width-1] = op[0] ? sgn : 1'b0;
      end
    end
    r = x;
  endfunction

  task automatic apply(input logic [63:0] d, input logic [7:0] raw,
      input logic [1:0] op, input logic w, input logic ci);
    @(negedge clk);
    opnd = d; raw_cnt = raw; op_sel = op; wide = w; cin = ci;
    #1;
  endtask

  task automatic check_ref(input string tag);
    logic [63:0] er;
    logic ec;
    ref_shift(opnd, raw_cnt, op_sel, wide, cin, er, ec);
    total++;
    if (res !== er || cout !== ec) begin
      bad++;
      $display("FAIL %s: op=%b wide=%b cnt=%0d d=%h cin=%b res=%h cout=%b expected res=%h cout=%b",
               tag, op_sel, wide, raw_cnt, opnd, cin, res, cout, er, ec);
    end
  endtask

  function automatic string tag_for(input logic [1:0] op);
    case (op)
      2'b00, 2'b01: return "R3 R4";
      2'b10:        return "R5 R6";
      default:      return "R5 R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r0;
    logic        c0;
    void'($urandom(32'h5a17));
    opnd = '0; raw_cnt = '0; op_sel = '0; wide = 1'b0; cin = 1'b0;
    #1;
    total++;
    if (res !== 64'h0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R8 idle: res=%h cout=%b expected res=0 cout=0", res, cout);
    end

    // Sweep: every op, both modes, every raw count, random operands.
    for (int op = 0; op < 4; op++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 256; c++)
          for (int k = 0; k < 3; k++) begin
            logic [63:0] d = {$urandom, $urandom};
            if (k == 1) d[w ? 63 : 31] = 1'b1;
            apply(d, 8'(c), 2'(op), w[0], 1'($urandom));
            check_ref(tag_for(2'(op)));
            if (w == 0) begin
              total++;
              if (res[63:32] !== 32'h0) begin
                bad++;
                $display("FAIL R9: upper=%h expected 0", res[63:32]);
              end
            end
          end

    // R1: count 33 in narrow mode acts like 1
    apply(64'hDEAD_BEEF_8000_0001, 8'd1, 2'b10, 1'b0, 1'b0);
    r0 = res; c0 = cout;
    apply(64'hDEAD_BEEF_8000_0001, 8'd33, 2'b10, 1'b0, 1'b0);
    total++;
    if (res !== r0 || cout !== c0) begin
      bad++;
      $display("FAIL R1: res=%h cout=%b expected res=%h cout=%b", res, cout, r0, c0);
    end

    // R2: count 65 in wide mode acts like 1
    apply(64'h8000_0000_0000_0003, 8'd1, 2'b11, 1'b1, 1'b0);
    r0 = res; c0 = cout;
    apply(64'h8000_0000_0000_0003, 8'd65, 2'b11, 1'b1, 1'b0);
    total++;
    if (res !== r0 || cout !== c0 || r0 !== 64'hC000_0000_0000_0001 || c0 !== 1'b1) begin
      bad++;
      $display("FAIL R2: res=%h cout=%b expected res=c000000000000001 cout=1", res, cout);
    end

    // R8: narrow count 32 masks to zero, carry passes through
    apply(64'hFFFF_FFFF_1234_5678, 8'd32, 2'b00, 1'b0, 1'b1);
    total++;
    if (res !== 64'h0000_0000_1234_5678 || cout !== 1'b1) begin
      bad++;
      $display("FAIL R8: res=%h cout=%b expected res=0000000012345678 cout=1", res, cout);
    end

    // R4: left by 63 in wide mode, carry from bit 1
    apply(64'h0000_0000_0000_0002, 8'd63, 2'b00, 1'b1, 1'b0);
    total++;
    if (res !== 64'h0 || cout !== 1'b1) begin
      bad++;
      $display("FAIL R4: res=%h cout=%b expected res=0 cout=1", res, cout);
    end

    // R7: arithmetic right by 31 in narrow mode
    apply(64'h0000_0000_8000_0000, 8'd31, 2'b11, 1'b0, 1'b0);
    total++;
    if (res !== 64'h0000_0000_FFFF_FFFF || cout !== 1'b0) begin
      bad++;
      $display("FAIL R7: res=%h cout=%b expected res=00000000ffffffff cout=0", res, cout);
    end

    // R6 and R5: logical right by 4, carry from bit 3
    apply(64'hF000_0000_0000_0008, 8'd4, 2'b10, 1'b1, 1'b0);
    total++;
    if (res !== 64'h0F00_0000_0000_0000 || cout !== 1'b1) begin
      bad++;
      $display("FAIL R6 R5: res=%h cout=%b expected res=0f00000000000000 cout=1", res, cout);
    end

    // R10: codes 00 and 01 agree
    for (int k = 0; k < 16; k++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [7:0]  cc = 8'($urandom);
      apply(d, cc, 2'b00, k[0], k[1]);
      r0 = res; c0 = cout;
      apply(d, cc, 2'b01, k[0], k[1]);
      total++;
      if (res !== r0 || cout !== c0) begin
        bad++;
        $display("FAIL R10: res=%h cout=%b expected res=%h cout=%b", res, cout, r0, c0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule